// File: doc/BRIEF.md
# R-Format Single-Cycle Processor Core

This block is a small 32-bit processor core that runs only register-to-register instructions, and it finishes each one in one clock period. A program counter drives a fetch address. The instruction word comes back combinationally from an instruction memory that sits outside the block. The core splits the word into its fields, reads two source registers from a 32-entry register file and combines them in an ALU. The result lands in the destination register at the next rising edge. Code runs straight through: the counter steps by four bytes every cycle, and there is no branch, jump, load, store or data memory.

Register contents are loaded by the environment through a debug write port. A debug read port exposes any register combinationally, so software-free test environments can check results. A decode failure raises an illegal-instruction flag and blocks the write-back. An ALU zero flag reports whether the current result is zero.

Top module: `rcore_top`

## Requirements
- R1: Reset `rst` is synchronous and active high. At a rising edge with `rst` high the PC becomes 0. While `rst` stays high the PC holds 0 and the core writes no register.
- R2: Outside reset the PC grows by 4 at every rising edge, wrapping modulo 2^32. `fetchAddr` always equals the PC.
- R3: The instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6] and funct [5:0]. The operation is rd = rs op rt. For example, 0x012A4020 adds r9 and r10 into r8.
- R4: With opcode 0, funct 0x20 adds, 0x22 subtracts (rs minus rt), 0x24 gives bitwise AND and 0x25 gives bitwise OR. Arithmetic wraps modulo 2^32 and overflow is not reported.
- R5: The result is written at the rising edge that ends the instruction's cycle. Register reads are combinational, so the next instruction sees the new value.
- R6: Register 0 always reads 0. A write to register 0, from the core or from the debug port, changes nothing.
- R7: A nonzero opcode, or any funct other than the four above, drives `illegalInstr` high in that cycle and leaves every register unchanged.
- R8: For a legal instruction, `aluZero` is high exactly when the ALU result is zero.
- R9: When `dbgWe` is high at a rising edge, `dbgData` is written to register `dbgAddr`. This write takes precedence over a core write to the same register at that edge. `dbgRdData` shows register `dbgRdAddr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetchAddr | output | 32 | Byte address of the current instruction (PC) |
| fetchInstr | input | 32 | Instruction word returned for `fetchAddr` |
| illegalInstr | output | 1 | Current instruction cannot be decoded |
| aluZero | output | 1 | ALU result of the current instruction is zero |
| dbgWe | input | 1 | Debug register write enable |
| dbgAddr | input | 5 | Debug write register index |
| dbgData | input | 32 | Debug write data |
| dbgRdAddr | input | 5 | Debug read register index |
| dbgRdData | output | 32 | Contents of register `dbgRdAddr` |

## Verification
The bound checker checks five things on every cycle: the PC returns to zero after reset and steps by four outside it, register 0 reads as zero, a debug write is visible at the next edge, and a cycle flagged illegal leaves the observed register untouched. The bench scenarios show the rest. They cover the arithmetic value of each operation, including the wrap, and they show that a result written by one instruction is used by the next. They also show the zero flag, that the core makes no write while reset is held, and that the debug port wins a write conflict on the same register.

// File: rtl/rcore_pkg.sv
`timescale 1ns/1ps
package rcore_pkg;
  localparam int OPC_W   = 6;
  localparam int REG_AW  = 5;
  localparam int SHAMT_W = 5;
  localparam int FUNCT_W = 6;

  localparam logic [FUNCT_W-1:0] FN_ADD = 6'h20;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'h22;
  localparam logic [FUNCT_W-1:0] FN_AND = 6'h24;
  localparam logic [FUNCT_W-1:0] FN_OR  = 6'h25;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_OR  = 2'd3
  } aluOp_e;

  typedef struct packed {
    logic   regWrite;
    aluOp_e aluOp;
    logic   illegal;
  } ctrlStrobes_t;

  typedef struct packed {
    logic [OPC_W-1:0]   opcode;
    logic [REG_AW-1:0]  rs;
    logic [REG_AW-1:0]  rt;
    logic [REG_AW-1:0]  rd;
    logic [SHAMT_W-1:0] shamt;
    logic [FUNCT_W-1:0] funct;
  } rInstr_t;
endpackage

// File: rtl/rcore_ctrl.sv
`timescale 1ns/1ps
module rcore_ctrl
  import rcore_pkg::*;
(
  input  logic               rst,
  input  logic [OPC_W-1:0]   opcode,
  input  logic [FUNCT_W-1:0] funct,
  output ctrlStrobes_t       strobes
);
  logic legal;

  always_comb begin
    strobes       = '0;
    strobes.aluOp = ALU_ADD;
    legal         = 1'b1;
    case (funct)
      FN_ADD:  strobes.aluOp = ALU_ADD;
      FN_SUB:  strobes.aluOp = ALU_SUB;
      FN_AND:  strobes.aluOp = ALU_AND;
      FN_OR:   strobes.aluOp = ALU_OR;
      default: legal = 1'b0;
    endcase
    if (opcode != '0) legal = 1'b0;
    strobes.illegal  = ~legal;
    strobes.regWrite = legal & ~rst;
  end
endmodule

// File: rtl/rcore_alu.sv
`timescale 1ns/1ps
module rcore_alu
  import rcore_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  aluOp_e          op,
  output logic [XLEN-1:0] result,
  output logic            zero
);
  always_comb begin
    case (op)
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      default: result = '0;
    endcase
  end

  assign zero = (result == '0);
endmodule

// File: rtl/rcore_regfile.sv
`timescale 1ns/1ps
module rcore_regfile #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic [AW-1:0]   rdAddrA,
  output logic [XLEN-1:0] rdDataA,
  input  logic [AW-1:0]   rdAddrB,
  output logic [XLEN-1:0] rdDataB,
  input  logic [AW-1:0]   rdAddrC,
  output logic [XLEN-1:0] rdDataC,
  input  logic            coreWe,
  input  logic [AW-1:0]   coreAddr,
  input  logic [XLEN-1:0] coreData,
  input  logic            dbgWe,
  input  logic [AW-1:0]   dbgAddr,
  input  logic [XLEN-1:0] dbgData
);
  logic [XLEN-1:0] regs [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs[i] = '0;
    end else begin : g_live
      logic [XLEN-1:0] q;
      always_ff @(posedge clk) begin
        if (dbgWe && dbgAddr == AW'(i))
          q <= dbgData;
        else if (coreWe && coreAddr == AW'(i))
          q <= coreData;
      end
      assign regs[i] = q;
    end
  end

  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];
  assign rdDataC = regs[rdAddrC];
endmodule

// File: rtl/rcore_dp.sv
`timescale 1ns/1ps
module rcore_dp
  import rcore_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int REG_COUNT  = 32,
  parameter int INSTR_BYTES = 4,
  localparam int AW        = $clog2(REG_COUNT)
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrlStrobes_t    strobes,
  input  logic [AW-1:0]   rsIdx,
  input  logic [AW-1:0]   rtIdx,
  input  logic [AW-1:0]   rdIdx,
  output logic [XLEN-1:0] pc,
  output logic            aluZero,
  input  logic            dbgWe,
  input  logic [AW-1:0]   dbgAddr,
  input  logic [XLEN-1:0] dbgData,
  input  logic [AW-1:0]   dbgRdAddr,
  output logic [XLEN-1:0] dbgRdData
);
  logic [XLEN-1:0] pcNext;
  logic [XLEN-1:0] srcA;
  logic [XLEN-1:0] srcB;
  logic [XLEN-1:0] aluResult;
  logic            wbEnable;

  assign pcNext = pc + XLEN'(INSTR_BYTES);

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  assign wbEnable = strobes.regWrite & ~strobes.illegal;

  rcore_regfile #(.XLEN(XLEN), .DEPTH(REG_COUNT)) rf_i (
    .clk      (clk),
    .rdAddrA  (rsIdx),
    .rdDataA  (srcA),
    .rdAddrB  (rtIdx),
    .rdDataB  (srcB),
    .rdAddrC  (dbgRdAddr),
    .rdDataC  (dbgRdData),
    .coreWe   (wbEnable),
    .coreAddr (rdIdx),
    .coreData (aluResult),
    .dbgWe    (dbgWe),
    .dbgAddr  (dbgAddr),
    .dbgData  (dbgData)
  );

  rcore_alu #(.XLEN(XLEN)) alu_i (
    .opA    (srcA),
    .opB    (srcB),
    .op     (strobes.aluOp),
    .result (aluResult),
    .zero   (aluZero)
  );
endmodule

// File: rtl/rcore_top.sv
`timescale 1ns/1ps
module rcore_top
  import rcore_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_COUNT = 32,
  localparam int AW       = $clog2(REG_COUNT)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] fetchAddr,
  input  logic [31:0]     fetchInstr,
  output logic            illegalInstr,
  output logic            aluZero,
  input  logic            dbgWe,
  input  logic [AW-1:0]   dbgAddr,
  input  logic [XLEN-1:0] dbgData,
  input  logic [AW-1:0]   dbgRdAddr,
  output logic [XLEN-1:0] dbgRdData
);
  rInstr_t      instr;
  ctrlStrobes_t strobes;

  assign instr = fetchInstr;

  rcore_ctrl ctrl_i (
    .rst     (rst),
    .opcode  (instr.opcode),
    .funct   (instr.funct),
    .strobes (strobes)
  );

  rcore_dp #(.XLEN(XLEN), .REG_COUNT(REG_COUNT)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .rsIdx     (AW'(instr.rs)),
    .rtIdx     (AW'(instr.rt)),
    .rdIdx     (AW'(instr.rd)),
    .pc        (fetchAddr),
    .aluZero   (aluZero),
    .dbgWe     (dbgWe),
    .dbgAddr   (dbgAddr),
    .dbgData   (dbgData),
    .dbgRdAddr (dbgRdAddr),
    .dbgRdData (dbgRdData)
  );

  assign illegalInstr = strobes.illegal;
endmodule

// File: rtl/rcore_checker.sv
`timescale 1ns/1ps
module rcore_checker #(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] fetchAddr,
  input logic            illegalInstr,
  input logic            dbgWe,
  input logic [AW-1:0]   dbgAddr,
  input logic [XLEN-1:0] dbgData,
  input logic [AW-1:0]   dbgRdAddr,
  input logic [XLEN-1:0] dbgRdData
);
  logic started = 1'b0;
  always_ff @(posedge clk) if (rst) started <= 1'b1;

  AST_PC_RESET: assert property (@(posedge clk) disable iff (rst)
    (started && $past(rst)) |-> fetchAddr == '0); // R1

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst)) |-> fetchAddr == $past(fetchAddr) + XLEN'(4)); // R2

  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (started && dbgRdAddr == '0) |-> dbgRdData == '0); // R6

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (started && $past(illegalInstr && !dbgWe && !rst) && $stable(dbgRdAddr))
      |-> $stable(dbgRdData)); // R7

  AST_DBG_WRITE_SEEN: assert property (@(posedge clk) disable iff (rst)
    (started && $past(dbgWe && dbgAddr != '0) && dbgRdAddr == $past(dbgAddr))
      |-> dbgRdData == $past(dbgData)); // R9
endmodule

bind rcore_top rcore_checker #(.XLEN(XLEN), .AW(AW)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .fetchAddr    (fetchAddr),
  .illegalInstr (illegalInstr),
  .dbgWe        (dbgWe),
  .dbgAddr      (dbgAddr),
  .dbgData      (dbgData),
  .dbgRdAddr    (dbgRdAddr),
  .dbgRdData    (dbgRdData)
);

// File: tb/rcore_top_tb_top.sv
`timescale 1ns/1ps
module rcore_top_tb_top;
  // 125 MHz clock: 8 ns period
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetchAddr;
  logic [31:0] fetchInstr;
  logic        illegalInstr;
  logic        aluZero;
  logic        dbgWe = 1'b0;
  logic [4:0]  dbgAddr = '0;
  logic [31:0] dbgData = '0;
  logic [4:0]  dbgRdAddr = '0;
  logic [31:0] dbgRdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  rcore_top dut_i (
    .clk(clk), .rst(rst), .fetchAddr(fetchAddr), .fetchInstr(fetchInstr),
    .illegalInstr(illegalInstr), .aluZero(aluZero), .dbgWe(dbgWe),
    .dbgAddr(dbgAddr), .dbgData(dbgData), .dbgRdAddr(dbgRdAddr),
    .dbgRdData(dbgRdData)
  );

  // {instr, rd, expected rd value, expected illegal, expected zero}
  localparam int NVEC = 13;
  localparam logic [70:0] VEC [NVEC] = '{
    {32'h012A4020, 5'd8,  32'd123,       1'b0, 1'b0}, // R3 add r8=r9+r10
    {32'h00222822, 5'd5,  32'd2,         1'b0, 1'b0}, // R4 sub 5-3
    {32'h00413022, 5'd6,  32'hFFFFFFFE,  1'b0, 1'b0}, // R4 sub 3-5 wraps
    {32'h00613820, 5'd7,  32'd4,         1'b0, 1'b0}, // R4 add wraps
    {32'h00645824, 5'd11, 32'h0F0F00FF,  1'b0, 1'b0}, // R4 and
    {32'h00226025, 5'd12, 32'd7,         1'b0, 1'b0}, // R4 or
    {32'h00216822, 5'd13, 32'd0,         1'b0, 1'b1}, // R8 zero result
    {32'h00220020, 5'd0,  32'd0,         1'b0, 1'b0}, // R6 write to r0
    {32'h00227021, 5'd14, 32'hDEADBEEF,  1'b1, 1'b0}, // R7 bad funct
    {32'h20227820, 5'd15, 32'h12345678,  1'b1, 1'b0}, // R7 bad opcode
    {32'h01058020, 5'd16, 32'd125,       1'b0, 1'b0}, // R5 uses r8,r5
    {32'h02008820, 5'd17, 32'd125,       1'b0, 1'b0}, // R5 uses r16 next cycle
    {32'h00019022, 5'd18, 32'hFFFFFFFB,  1'b0, 1'b0}  // R6 r0 as source
  };

  logic [31:0] imem [64];
  assign fetchInstr = imem[fetchAddr[7:2]];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic dbgWrite(input logic [4:0] a, input logic [31:0] d);
    dbgWe = 1'b1; dbgAddr = a; dbgData = d;
    @(posedge clk); @(negedge clk);
    dbgWe = 1'b0;
  endtask

  task automatic readReg(input string req, input logic [4:0] a, input logic [31:0] exp);
    dbgRdAddr = a;
    #1;
    chk(req, dbgRdData, exp);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) imem[i] = 32'h00000020;
    for (int i = 0; i < NVEC; i++) imem[i] = VEC[i][70:39];

    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pc", fetchAddr, 32'd0);

    dbgWrite(5'd1, 32'd5);
    dbgWrite(5'd2, 32'd3);
    dbgWrite(5'd3, 32'hFFFFFFFF);
    dbgWrite(5'd4, 32'h0F0F00FF);
    dbgWrite(5'd9, 32'd100);
    dbgWrite(5'd10, 32'd23);
    dbgWrite(5'd14, 32'hDEADBEEF);
    dbgWrite(5'd15, 32'h12345678);
    chk("R1 pc held in reset", fetchAddr, 32'd0);
    readReg("R9 debug write", 5'd9, 32'd100);
    readReg("R1 no core write in reset", 5'd8, 32'hx);

    rst = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      chk("R2 fetch address", fetchAddr, 32'(4 * i));
      chk("R7 illegal flag", {31'd0, illegalInstr}, {31'd0, VEC[i][1]});
      if (!VEC[i][1]) chk("R8 zero flag", {31'd0, aluZero}, {31'd0, VEC[i][0]});
      @(posedge clk); @(negedge clk);
      readReg("R3 R4 R5 result", VEC[i][38:34], VEC[i][33:2]);
    end

    // R1: reset mid-run, no core write while held (instr 0 would set r8=24)
    rst = 1'b1;
    dbgWrite(5'd9, 32'd1);
    @(posedge clk); @(negedge clk);
    chk("R1 pc after reset", fetchAddr, 32'd0);
    readReg("R1 r8 untouched in reset", 5'd8, 32'd123);

    // R9: debug write wins over core write of r8 at the same edge
    rst = 1'b0;
    dbgWrite(5'd8, 32'h00000077);
    readReg("R9 debug priority", 5'd8, 32'h00000077);
    chk("R2 pc after one step", fetchAddr, 32'd4);

    // R6: debug write to r0 ignored
    dbgWrite(5'd0, 32'h0000FFFF);
    readReg("R6 r0 after debug write", 5'd0, 32'd0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule